// File: doc/BRIEF.md
# Pushbutton Reset Debouncer

This block cleans up an active-low manual reset input before it reaches a chip's reset generator. The input may come from bouncing mechanical contacts or from another logic source, and it is asynchronous to the local clock. It first passes through a flop synchronizer. A divider then makes a one-cycle sampling strobe, nominally once per millisecond. The filtered input is read only on that strobe.

A press becomes a reset request only after the input has read low on a run of consecutive strobes. Any high reading restarts the run. Glitches shorter than one strobe period therefore never get through, and a press lasting the full run is always accepted. The run length sets the acceptance delay, which lies between those two limits and defaults to four strobes. The request is a level that stays high while the button is held. Release is filtered the same way: the request drops only after a run of consecutive high readings. The reset generator downstream stretches the request into its own reset-active period.

Top module: `pbreset_filter`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `rst_req` is 0. This holds even if the button is pressed at the time.
- R2: A low pulse on `btn_n` that is shorter than one strobe period (`CLKS_PER_TICK` clock cycles) never raises `rst_req`.
- R3: A low pulse on `btn_n` lasting at least `HOLD_TICKS * CLKS_PER_TICK` clock cycles always raises `rst_req`.
- R4: A low pulse of at most `(HOLD_TICKS-1) * CLKS_PER_TICK` cycles never raises `rst_req`. This also applies to a train of such pulses separated by high gaps of at least one strobe period.
- R5: When `btn_n` falls and then stays low, `rst_req` rises between `(HOLD_TICKS-1)*CLKS_PER_TICK+3` and `HOLD_TICKS*CLKS_PER_TICK+2` clock cycles later. It rises only after a strobe at which the synchronized input read low.
- R6: While `btn_n` stays low, `rst_req` stays 1.
- R7: Once `rst_req` is 1, high pulses of at most `(HOLD_TICKS-1)*CLKS_PER_TICK` cycles do not clear it. It falls only after a strobe at which the synchronized input read high.
- R8: When `btn_n` returns high and then stays high, `rst_req` falls between `(HOLD_TICKS-1)*CLKS_PER_TICK+3` and `HOLD_TICKS*CLKS_PER_TICK+2` clock cycles later.
- R9: `rst_req` changes only in the cycle right after a sampling strobe, and strobes are never on in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_n | input | 1 | Raw manual reset input, asynchronous, low means pressed |
| rst_req | output | 1 | Debounced reset request level to the reset generator |

## Verification
The bench sweeps low-pulse widths across every phase relative to the strobe. It checks that pulses at or below one short of the run are always dropped and that pulses of the full run are always taken. A design with an off-by-one in the run count, or one that does not clear the run on a high reading, would break one of these two limits. Press and release latencies are measured against exact cycle windows that include the synchronizer delay, so a missing or extra register stage shows up. Release bounce while the request is held checks that a design which drops the request on the first high reading is caught. Reset during a held press checks that the request clears at once and comes back only after a fresh run.

// File: rtl/pbrf_pkg.sv
package pbrf_pkg;

    // Width of the consecutive-reading run counter.
    localparam int unsigned RUN_W = 8;

    typedef logic [RUN_W-1:0] run_t;

    // Filter state: whether a press is currently accepted.
    typedef enum logic {
        ST_OPEN    = 1'b0,
        ST_PRESSED = 1'b1
    } press_e;

    typedef struct packed {
        press_e state;
        run_t   run;
    } filt_s;

    // Advance the run of readings that disagree with the current state.
    // A reading that agrees with the state restarts the run; the run
    // saturates at the limit.
    function automatic run_t run_step(run_t run, logic differs, run_t limit);
        if (!differs)
            return '0;
        else if (run >= limit)
            return limit;
        else
            return run + run_t'(1);
    endfunction

endpackage

// File: rtl/pbrf_sync.sv
module pbrf_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RESET_VAL;
                else     chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RESET_VAL}};
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/pbrf_tick.sv
module pbrf_tick #(
    parameter int unsigned CLKS_PER_TICK = 50000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = (CLKS_PER_TICK > 2) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_TICK - 1);

    logic [CW-1:0] div_q;
    logic          tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            tick_q <= 1'b0;
        end else if (div_q == LAST) begin
            div_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            div_q  <= div_q + CW'(1);
            tick_q <= 1'b0;
        end
    end

    assign tick = tick_q;
endmodule

// File: rtl/pbrf_filter.sv
module pbrf_filter
    import pbrf_pkg::*;
#(
    parameter int unsigned HOLD_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic btn_low,
    output logic req
);
    localparam run_t RUN_LIMIT = run_t'(HOLD_TICKS);

    filt_s cur_q, nxt;
    logic  differs;
    run_t  run_nxt;

    always_comb begin
        nxt     = cur_q;
        differs = (cur_q.state == ST_OPEN) ? btn_low : !btn_low;
        run_nxt = run_step(cur_q.run, differs, RUN_LIMIT);
        if (tick) begin
            if (run_nxt == RUN_LIMIT) begin
                nxt.state = (cur_q.state == ST_OPEN) ? ST_PRESSED : ST_OPEN;
                nxt.run   = '0;
            end else begin
                nxt.run   = run_nxt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.state <= ST_OPEN;
            cur_q.run   <= '0;
        end else begin
            cur_q <= nxt;
        end
    end

    assign req = (cur_q.state == ST_PRESSED);
endmodule

// File: rtl/pbreset_filter.sv
module pbreset_filter #(
    parameter int unsigned CLKS_PER_TICK = 50000,
    parameter int unsigned HOLD_TICKS    = 4,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_n,
    output logic rst_req
);
    logic btn_level;
    logic btn_low;
    logic tick;

    pbrf_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  (btn_n),
        .dout (btn_level)
    );

    pbrf_tick #(
        .CLKS_PER_TICK (CLKS_PER_TICK)
    ) tick_i (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    assign btn_low = !btn_level;

    pbrf_filter #(
        .HOLD_TICKS (HOLD_TICKS)
    ) filt_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .btn_low (btn_low),
        .req     (rst_req)
    );
endmodule

// File: rtl/pbreset_filter_chk.sv
module pbreset_filter_chk (
    input logic clk,
    input logic rst,
    input logic btn_level,
    input logic tick,
    input logic rst_req
);
    // R1
    req_clear_chk: assert property (@(posedge clk) rst |=> !rst_req);

    // R9
    req_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_req != $past(rst_req)) |-> $past(tick));

    // R9
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R5
    rise_on_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> !$past(btn_level));

    // R7
    fall_on_high_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_req) |-> $past(btn_level));

    // R6
    hold_low_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_req && !btn_level) |=> rst_req);
endmodule

bind pbreset_filter pbreset_filter_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .btn_level (btn_level),
    .tick      (tick),
    .rst_req   (rst_req)
);

// File: tb/pbreset_filter_tb_top.sv
module pbreset_filter_tb_top;
    localparam int P = 5;
    localparam int N = 4;
    localparam int LAT_MIN = (N-1)*P + 3;
    localparam int LAT_MAX = N*P + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_n = 1'b1;
    logic rst_req;
    logic saw_hi = 1'b0;
    logic saw_lo = 1'b0;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    pbreset_filter #(
        .CLKS_PER_TICK (P),
        .HOLD_TICKS    (N),
        .SYNC_STAGES   (2)
    ) dut_i (
        .clk     (clk),
        .rst     (rst),
        .btn_n   (btn_n),
        .rst_req (rst_req)
    );

    always @(negedge clk) begin
        if (rst_req === 1'b1) saw_hi = 1'b1;
        else                  saw_lo = 1'b1;
    end

    task automatic check(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // Count cycles until rst_req reaches the wanted level.
    task automatic measure(logic want, output int n);
        n = 0;
        while (rst_req !== want && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int lat;
        wait_cyc(3);
        check(rst_req === 1'b0, "R1 req low in reset", int'(rst_req), 0);
        rst = 1'b0;
        wait_cyc(1);
        check(rst_req === 1'b0, "R1 req low after reset", int'(rst_req), 0);
        wait_cyc(3*P);

        // R2 R3 R4: width sweep over all strobe phases
        for (int ph = 0; ph < P; ph++) begin
            for (int w = 1; w <= (N+2)*P; w++) begin
                wait_cyc(ph);
                saw_hi = 1'b0;
                btn_n = 1'b0;
                wait_cyc(w);
                btn_n = 1'b1;
                wait_cyc(2*(N+1)*P);
                if (w < P)
                    check(!saw_hi, "R2 sub-strobe glitch rejected", int'(saw_hi), 0);
                else if (w <= (N-1)*P)
                    check(!saw_hi, "R4 short pulse rejected", int'(saw_hi), 0);
                else if (w >= N*P)
                    check(saw_hi, "R3 long pulse accepted", int'(saw_hi), 1);
                check(rst_req === 1'b0, "R8 request released after pulse", int'(rst_req), 0);
            end
        end

        // R4: train of short pulses with strobe-long gaps
        saw_hi = 1'b0;
        repeat (5) begin
            btn_n = 1'b0; wait_cyc((N-1)*P);
            btn_n = 1'b1; wait_cyc(P);
        end
        wait_cyc(N*P);
        check(!saw_hi, "R4 pulse train rejected", int'(saw_hi), 0);

        // R5 R6 R7 R8 over several start phases
        for (int ph = 0; ph < P; ph++) begin
            wait_cyc(ph + 1);
            btn_n = 1'b0;
            measure(1'b1, lat);
            check(lat >= LAT_MIN && lat <= LAT_MAX, "R5 press latency", lat, LAT_MIN);
            for (int k = 0; k < 4; k++) begin
                wait_cyc(2*P);
                check(rst_req === 1'b1, "R6 held while low", int'(rst_req), 1);
            end
            saw_lo = 1'b0;
            repeat (3) begin
                btn_n = 1'b1; wait_cyc((N-1)*P);
                btn_n = 1'b0; wait_cyc(P);
            end
            wait_cyc(2);
            check(!saw_lo, "R7 release bounce ignored", int'(saw_lo), 0);
            btn_n = 1'b1;
            measure(1'b0, lat);
            check(lat >= LAT_MIN && lat <= LAT_MAX, "R8 release latency", lat, LAT_MIN);
            wait_cyc(2*P);
        end

        // R1: reset during a held press
        btn_n = 1'b0;
        measure(1'b1, lat);
        wait_cyc(P);
        rst = 1'b1;
        wait_cyc(1);
        check(rst_req === 1'b0, "R1 reset clears held request", int'(rst_req), 0);
        wait_cyc(2);
        rst = 1'b0;
        wait_cyc(1);
        check(rst_req === 1'b0, "R1 request stays low after reset", int'(rst_req), 0);
        measure(1'b1, lat);
        check(lat >= LAT_MIN - 1 && lat <= LAT_MAX, "R5 fresh run after reset", lat, LAT_MIN);
        btn_n = 1'b1;
        measure(1'b0, lat);
        check(rst_req === 1'b0, "R8 release after reset run", int'(rst_req), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule